// File: doc/BRIEF.md
# Call/Return Frame Sequencer

This block performs subroutine entry and exit against a stack kept in word-addressed memory. It owns three architectural registers: the program counter, the stack pointer and the frame pointer. A call command builds a three-word frame below the current stack pointer. The frame holds a link address, an unused static-chain word and the caller's frame pointer. The command then moves the program counter to the call target. A return command removes the frame again, using the frame pointer as its anchor.

The sequencer takes one command at a time on a valid strobe and is only accepted while idle. Each memory access is a single 32-bit word transfer that completes when the memory raises ready. The three registers change together in a final commit cycle, after which the block is idle again. Instruction decode, the general registers and memory timing beyond the handshake are outside this block.

Top module: `frame_seq`

## Requirements
- R1: After reset, busy and mem_req are low and pc_out, sp_out and fp_out hold the parameters RESET_PC, RESET_SP and RESET_FP.
- R2: The first access of a call (cmd_ret=0) is a write (mem_we=1) of the link address to old SP minus 8.
- R3: The link address is PC plus 6 when cmd_indirect=0 (absolute target from tgt_imm) and PC plus 2 when cmd_indirect=1 (target from tgt_reg).
- R4: The second access of a call is a write of the old FP to old SP minus 12.
- R5: When a call completes, SP and FP both equal old SP minus 12, and PC equals tgt_imm when cmd_indirect=0 or tgt_reg when cmd_indirect=1.
- R6: A return (cmd_ret=1) makes exactly two reads: the first at old FP, the second at old FP plus 4.
- R7: When a return completes, FP equals the data of the first read, PC equals the data of the second read, and SP equals old FP plus 12.
- R8: Each access keeps mem_req, mem_we, mem_addr and mem_wdata steady until mem_ready is high, so one access with L wait cycles takes L+1 cycles.
- R9: busy is high from the cycle after acceptance through a single commit cycle, for 2*(L+1)+1 cycles in all. pc_out, sp_out and fp_out do not change until the commit.
- R10: A command presented while busy, including one presented in the commit cycle, is not accepted. A command held valid past the commit is accepted on the first idle cycle, and it then works from the committed register values.
- R11: mem_req is low during the commit cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_ret | input | 1 | 1 = return, 0 = call |
| cmd_indirect | input | 1 | Call target from tgt_reg (1) or tgt_imm (0) |
| tgt_imm | input | 32 | Absolute call target |
| tgt_reg | input | 32 | Register-held call target |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| pc_out | output | 32 | Program counter |
| sp_out | output | 32 | Stack pointer |
| fp_out | output | 32 | Frame pointer |

## Verification
Two events can share a cycle: the register commit that ends one command, and the arrival of the next command on cmd_valid. The bench raises a return strobe during the commit cycle of a call and keeps it high into the following idle cycle. It checks that busy has dropped with the call's values committed, and that the return is then accepted. The return must read its frame at the newly committed FP and restore the pre-call registers. A strobe pulsed during a call's memory phase must leave no trace in the access log or in the registers.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam int unsigned XLEN       = 32;
  localparam int unsigned SLOT_BYTES = XLEN / 8;
  localparam int unsigned SHORT_LEN  = 2;
  localparam int unsigned LONG_LEN   = 6;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_RA,
    ST_PUSH_FP,
    ST_POP_FP,
    ST_POP_PC,
    ST_DONE
  } fseq_state_e;

  // link address left behind by a call
  function automatic word_t link_addr(input word_t pc, input logic indirect);
    return pc + (indirect ? word_t'(SHORT_LEN) : word_t'(LONG_LEN));
  endfunction

  // word touched by each access state, relative to the frame anchor
  function automatic word_t slot_addr(input word_t base, input fseq_state_e st);
    case (st)
      ST_PUSH_RA: return base - word_t'(2 * SLOT_BYTES);
      ST_PUSH_FP: return base - word_t'(3 * SLOT_BYTES);
      ST_POP_PC:  return base + word_t'(SLOT_BYTES);
      default:    return base;
    endcase
  endfunction

  // stack pointer once the frame has been built or removed
  function automatic word_t settled_sp(input word_t base, input logic is_ret);
    return is_ret ? base + word_t'(3 * SLOT_BYTES) : base - word_t'(3 * SLOT_BYTES);
  endfunction
endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_ret,
  input  logic        mem_ready,
  output fseq_state_e state,
  output logic        mem_req,
  output logic        accept,
  output logic        step,
  output logic        commit,
  output logic        busy
);
  fseq_state_e state_d;

  assign mem_req = (state == ST_PUSH_RA) || (state == ST_PUSH_FP) ||
                   (state == ST_POP_FP)  || (state == ST_POP_PC);
  assign accept  = (state == ST_IDLE) && cmd_valid;
  assign step    = mem_req && mem_ready;
  assign commit  = (state == ST_DONE);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE:    if (cmd_valid) state_d = cmd_ret ? ST_POP_FP : ST_PUSH_RA;
      ST_PUSH_RA: if (mem_ready) state_d = ST_PUSH_FP;
      ST_PUSH_FP: if (mem_ready) state_d = ST_DONE;
      ST_POP_FP:  if (mem_ready) state_d = ST_POP_PC;
      ST_POP_PC:  if (mem_ready) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  // R8
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && state == $past(state)));

  // R10
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (state != ST_PUSH_RA && state != ST_POP_FP));
endmodule

// File: rtl/fseq_frame.sv
module fseq_frame
  import fseq_pkg::*;
#(
  parameter word_t RESET_PC = 32'h0000_0040,
  parameter word_t RESET_SP = 32'h0000_0200,
  parameter word_t RESET_FP = 32'h0000_0200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  fseq_state_e state,
  input  logic        mem_req,
  input  logic        accept,
  input  logic        step,
  input  logic        commit,
  input  logic        cmd_ret,
  input  logic        cmd_indirect,
  input  word_t       tgt_imm,
  input  word_t       tgt_reg,
  input  word_t       mem_rdata,
  output word_t       mem_addr,
  output logic        mem_we,
  output word_t       mem_wdata,
  output word_t       pc_q,
  output word_t       sp_q,
  output word_t       fp_q
);
  logic  is_ret;
  word_t base;
  word_t link;
  word_t nxt_pc;
  word_t nxt_fp;

  assign mem_addr  = slot_addr(base, state);
  assign mem_we    = (state == ST_PUSH_RA) || (state == ST_PUSH_FP);
  assign mem_wdata = (state == ST_PUSH_RA) ? link :
                     (state == ST_PUSH_FP) ? fp_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_ret <= 1'b0;
      base   <= '0;
      link   <= '0;
      nxt_pc <= '0;
      nxt_fp <= '0;
    end else if (accept) begin
      is_ret <= cmd_ret;
      base   <= cmd_ret ? fp_q : sp_q;
      link   <= link_addr(pc_q, cmd_indirect);
      nxt_pc <= cmd_indirect ? tgt_reg : tgt_imm;
      nxt_fp <= settled_sp(sp_q, 1'b0);
    end else if (step && state == ST_POP_FP) begin
      nxt_fp <= mem_rdata;
    end else if (step && state == ST_POP_PC) begin
      nxt_pc <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
      sp_q <= RESET_SP;
      fp_q <= RESET_FP;
    end else if (commit) begin
      pc_q <= nxt_pc;
      sp_q <= settled_sp(base, is_ret);
      fp_q <= nxt_fp;
    end
  end

  // R9
  arch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(pc_q) && $stable(sp_q) && $stable(fp_q)));

  // R5
  call_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !is_ret) |=> (sp_q == fp_q));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !step) |=> ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import fseq_pkg::*;
#(
  parameter logic [fseq_pkg::XLEN-1:0] RESET_PC = 32'h0000_0040,
  parameter logic [fseq_pkg::XLEN-1:0] RESET_SP = 32'h0000_0200,
  parameter logic [fseq_pkg::XLEN-1:0] RESET_FP = 32'h0000_0200
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic                      cmd_ret,
  input  logic                      cmd_indirect,
  input  logic [fseq_pkg::XLEN-1:0] tgt_imm,
  input  logic [fseq_pkg::XLEN-1:0] tgt_reg,
  output logic                      busy,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [fseq_pkg::XLEN-1:0] mem_addr,
  output logic [fseq_pkg::XLEN-1:0] mem_wdata,
  input  logic [fseq_pkg::XLEN-1:0] mem_rdata,
  input  logic                      mem_ready,
  output logic [fseq_pkg::XLEN-1:0] pc_out,
  output logic [fseq_pkg::XLEN-1:0] sp_out,
  output logic [fseq_pkg::XLEN-1:0] fp_out
);
  fseq_state_e state_w;
  logic        accept_w;
  logic        step_w;
  logic        commit_w;

  fseq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ret   (cmd_ret),
    .mem_ready (mem_ready),
    .state     (state_w),
    .mem_req   (mem_req),
    .accept    (accept_w),
    .step      (step_w),
    .commit    (commit_w),
    .busy      (busy)
  );

  fseq_frame #(
    .RESET_PC (RESET_PC),
    .RESET_SP (RESET_SP),
    .RESET_FP (RESET_FP)
  ) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state_w),
    .mem_req      (mem_req),
    .accept       (accept_w),
    .step         (step_w),
    .commit       (commit_w),
    .cmd_ret      (cmd_ret),
    .cmd_indirect (cmd_indirect),
    .tgt_imm      (tgt_imm),
    .tgt_reg      (tgt_reg),
    .mem_rdata    (mem_rdata),
    .mem_addr     (mem_addr),
    .mem_we       (mem_we),
    .mem_wdata    (mem_wdata),
    .pc_q         (pc_out),
    .sp_q         (sp_out),
    .fp_q         (fp_out)
  );

  // R11
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w |-> !mem_req);
endmodule

// File: tb/frame_seq_tb.sv
module frame_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] R_PC = 32'h0000_0040;
  localparam logic [31:0] R_SP = 32'h0000_0200;
  localparam logic [31:0] R_FP = 32'h0000_0200;

  typedef struct packed {
    logic        is_ret;
    logic        ind;
    logic [3:0]  lat;
    logic [31:0] imm;
    logic [31:0] rg;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b0, 1'b0, 4'd0, 32'h0000_1000, 32'hDEAD_0000},
    '{1'b0, 1'b1, 4'd2, 32'h0000_BAD0, 32'h0000_2000},
    '{1'b1, 1'b0, 4'd1, 32'h0,         32'h0},
    '{1'b0, 1'b1, 4'd0, 32'h0000_0000, 32'h0000_3004},
    '{1'b1, 1'b0, 4'd0, 32'h0,         32'h0},
    '{1'b1, 1'b0, 4'd3, 32'h0,         32'h0},
    '{1'b0, 1'b0, 4'd1, 32'h0000_5550, 32'h0000_7777},
    '{1'b1, 1'b0, 4'd0, 32'h0,         32'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ret = 1'b0, cmd_indirect = 1'b0;
  logic [31:0] tgt_imm = '0, tgt_reg = '0;
  logic busy, mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, pc_out, sp_out, fp_out;

  int n_checks = 0;
  int n_fail = 0;
  int lat = 0;
  int wait_cnt = 0;
  int nlog = 0;
  int cyc = 0;
  bit finished = 0;
  logic [31:0] mem [0:255];
  logic [31:0] log_addr [0:63];
  logic [31:0] log_data [0:63];
  logic        log_we   [0:63];
  logic [31:0] exp_pc = R_PC, exp_sp = R_SP, exp_fp = R_FP;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_seq #(.RESET_PC(R_PC), .RESET_SP(R_SP), .RESET_FP(R_FP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ret(cmd_ret),
    .cmd_indirect(cmd_indirect), .tgt_imm(tgt_imm), .tgt_reg(tgt_reg),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .pc_out(pc_out), .sp_out(sp_out), .fp_out(fp_out)
  );

  // memory model with programmable wait cycles
  assign mem_ready = mem_req && (wait_cnt >= lat);
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n || !mem_req || mem_ready) wait_cnt <= 0;
    else wait_cnt <= wait_cnt + 1;
    if (mem_req && mem_ready) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      log_addr[nlog[5:0]] <= mem_addr;
      log_data[nlog[5:0]] <= mem_we ? mem_wdata : mem_rdata;
      log_we[nlog[5:0]]   <= mem_we;
      nlog <= nlog + 1;
    end
    if (cyc > 20000 && !finished) begin
      finished = 1;
      n_checks = n_checks + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, act %0d exp < 20000 cycles", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, expv);
    end
  endtask

  task automatic check_regs(input string req);
    chk(pc_out == exp_pc, {req, " pc"}, pc_out, exp_pc);
    chk(sp_out == exp_sp, {req, " sp"}, sp_out, exp_sp);
    chk(fp_out == exp_fp, {req, " fp"}, fp_out, exp_fp);
  endtask

  // one command; inject=1 pulses a stray opposite command mid-flight
  task automatic do_op(input vec_t v, input bit inject);
    int start, nb;
    bit hold_ok;
    logic [31:0] o_pc, o_sp, o_fp, a0, a1, d0, d1;
    logic w;
    o_pc = exp_pc; o_sp = exp_sp; o_fp = exp_fp;
    if (!v.is_ret) begin
      w = 1'b1;
      a0 = o_sp - 8;  d0 = o_pc + (v.ind ? 32'd2 : 32'd6);
      a1 = o_sp - 12; d1 = o_fp;
    end else begin
      w = 1'b0;
      a0 = o_fp;      d0 = mem[o_fp[9:2]];
      a1 = o_fp + 4;  d1 = mem[a1[9:2]];
    end
    lat = int'(v.lat);
    start = nlog;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_ret = v.is_ret; cmd_indirect = v.ind;
    tgt_imm = v.imm; tgt_reg = v.rg;
    @(negedge clk);
    cmd_valid = 1'b0;
    nb = 0; hold_ok = 1;
    while (busy) begin
      nb++;
      if (pc_out != o_pc || sp_out != o_sp || fp_out != o_fp) hold_ok = 0;
      if (inject && nb == 1) begin cmd_valid = 1'b1; cmd_ret = ~v.is_ret; end
      if (inject && nb == 2) cmd_valid = 1'b0;
      @(negedge clk);
    end
    // R8 R9: each access lasts lat+1 cycles, plus one commit cycle
    chk(nb == 2 * (int'(v.lat) + 1) + 1, "R8 busy length", nb, 2 * (int'(v.lat) + 1) + 1);
    chk(hold_ok, "R9 registers held while busy", 32'(hold_ok), 32'd1);
    chk(nlog - start == 2, "R10 access count", nlog - start, 2);
    if (!v.is_ret) begin
      chk(log_we[start[5:0]] == w && log_addr[start[5:0]] == a0, "R2 link slot addr", log_addr[start[5:0]], a0);
      chk(log_data[start[5:0]] == d0, "R3 link address", log_data[start[5:0]], d0);
      chk(log_we[start[5:0]+6'd1] == w && log_addr[start[5:0]+6'd1] == a1, "R4 fp slot addr", log_addr[start[5:0]+6'd1], a1);
      chk(log_data[start[5:0]+6'd1] == d1, "R4 saved fp", log_data[start[5:0]+6'd1], d1);
      exp_sp = o_sp - 12; exp_fp = o_sp - 12;
      exp_pc = v.ind ? v.rg : v.imm;
      check_regs("R5 after call");
    end else begin
      chk(log_we[start[5:0]] == w && log_addr[start[5:0]] == a0, "R6 first read addr", log_addr[start[5:0]], a0);
      chk(log_we[start[5:0]+6'd1] == w && log_addr[start[5:0]+6'd1] == a1, "R6 second read addr", log_addr[start[5:0]+6'd1], a1);
      exp_fp = d0; exp_pc = d1; exp_sp = o_fp + 12;
      check_regs("R7 after return");
    end
    @(negedge clk);
    chk(!busy, "R10 no stray command", 32'(busy), 32'd0);
  endtask

  initial begin
    logic [31:0] c_pc, c_sp, c_fp;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req, "R1 idle after reset", {30'd0, busy, mem_req}, 32'd0);
    check_regs("R1 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    check_regs("R1 after release");

    for (int k = 0; k < 8; k++) do_op(VECS[k], 1'b0);

    // stray return pulse during a call's memory phase
    do_op('{1'b0, 1'b1, 4'd1, 32'h0, 32'h0000_6660}, 1'b1);
    do_op('{1'b1, 1'b0, 4'd0, 32'h0, 32'h0}, 1'b0);

    // return strobe raised in the commit cycle of a call
    c_pc = exp_pc; c_sp = exp_sp; c_fp = exp_fp;
    lat = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_ret = 1'b0; cmd_indirect = 1'b0; tgt_imm = 32'h0000_9990;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(busy && !mem_req, "R11 commit cycle quiet", {30'd0, busy, mem_req}, 32'd2);
    cmd_valid = 1'b1; cmd_ret = 1'b1;
    @(negedge clk);
    exp_pc = 32'h0000_9990; exp_sp = c_sp - 12; exp_fp = c_sp - 12;
    chk(!busy, "R10 not accepted in commit cycle", 32'(busy), 32'd0);
    check_regs("R10 call committed");
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && mem_req && !mem_we && mem_addr == c_sp - 12, "R10 held return accepted", mem_addr, c_sp - 12);
    while (busy) @(negedge clk);
    exp_pc = c_pc + 6; exp_sp = c_sp; exp_fp = c_fp;
    check_regs("R7 return after back-to-back");

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule